// File: doc/BRIEF.md
# Memory Read Bridge Sequencer

This block sits in the clock domain of a DDR-2 memory controller and turns read requests from a slower bus slave into controller commands and bus responses. A request is taken only while the sequencer is idle, the slave selects it, asks for a read, and the controller's address queue is not close to full. A single read pushes one address, waits for the controller to report valid data, and captures the word. It can spend one extra cycle so that the acknowledge lines up with the phase of the bus clock. It then drives the acknowledge and the word onto the bus for two cycles.

A burst read pushes a run of consecutive addresses and pauses whenever the queue is nearly full. Each address returns a pair of words. The sequencer writes these words into a staging FIFO by alternating between two capture states, one per word of the pair. It then waits for a separate drain machine to report that the last word of the bus transfer is completing. Only then does it accept new work.

Top module: `rdseq_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, `ack`, `bus_data`, `fifo_we` and `addr_push` are all 0.
- R2: A request is accepted only in the idle state with `sel`=1, `rd_req`=1 and `af_full`=0. Acceptance gives one `addr_push` pulse in the next cycle, with `addr_out` equal to `req_addr`. With any of the three conditions unmet, no push occurs.
- R3: A single read (`burst`=0) raises `ack` for exactly two consecutive cycles, with `bus_data` equal to the captured word in both. `bus_data` is 0 whenever `ack` is 0.
- R4: For a single read, the word on `rd_word` is captured at the clock edge where `rd_valid`=1. If `bus_clk_lvl` was 0 at that edge, `ack` rises in the next cycle. If it was 1, `ack` rises one cycle later.
- R5: After an address is issued, the sequencer waits for `rd_valid` for any number of cycles. No acknowledge and no FIFO write occur before valid data arrives.
- R6: A burst (`burst`=1) pushes `burst_len`+1 addresses: `req_addr`, `req_addr`+1, and so on. Each `addr_push` pulse follows a cycle in which `af_full` was 0.
- R7: A burst starts waiting for data one clock after its last address push. With `rd_valid` held at 1, the first FIFO write appears two cycles after the last push. `rd_valid` during the issue phase is ignored.
- R8: A burst writes exactly 2×(`burst_len`+1) words. Each write is a `fifo_we` pulse of one cycle, with `fifo_wdata` equal to `rd_word` at the capturing edge, in arrival order. Further `rd_valid` pulses write nothing.
- R9: After a burst's data is captured, requests are ignored until `drain_last`=1. A request is also ignored during a single read. After `drain_last`, the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-controller clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Slave chip-select |
| rd_req | input | 1 | Read request |
| burst | input | 1 | 1 = burst request, 0 = single read |
| burst_len | input | LEN_W | Address pairs in the burst, minus one |
| req_addr | input | ADDR_W | Start address |
| af_full | input | 1 | Controller address queue almost full |
| rd_valid | input | 1 | Controller read data valid |
| rd_word | input | DATA_W | Controller read data |
| bus_clk_lvl | input | 1 | Sampled level of the bus clock |
| drain_last | input | 1 | Drain machine completing the last bus word |
| ack | output | 1 | Read acknowledge to the bus |
| bus_data | output | DATA_W | Read data to the bus |
| fifo_we | output | 1 | Staging FIFO write strobe |
| fifo_wdata | output | DATA_W | Staging FIFO write data |
| addr_push | output | 1 | Push into the controller address queue |
| addr_out | output | ADDR_W | Address being pushed |

## Verification
The bench sweeps every burst length of a small configuration against several almost-full and read-valid patterns.
- A design that ignored `af_full` while issuing would push after a blocked cycle.
- A design that moved to waiting too early would capture a word that arrived during the issue phase.
- A design that miscounted the ping-pong loop would write one word too few or too many.

Single reads are run with both bus-clock levels and several valid delays. A missing alignment cycle would raise `ack` one cycle early. A design that reacted to requests outside idle, or during the drain wait, would emit a stray address push.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_ALIGN, ST_ACK1, ST_ACK2, ST_QW1, ST_QW2, ST_DRAIN
  } rdseq_state_e;
endpackage

// File: rtl/rdseq_issue.sv
module rdseq_issue #(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_burst,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  input  logic              af_full,
  output logic              addr_push,
  output logic [ADDR_W-1:0] addr_out,
  output logic              last_pushed
);
  logic              busy_q;
  logic [LEN_W-1:0]  left_q;
  logic [ADDR_W-1:0] next_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_push   <= 1'b0;
      last_pushed <= 1'b0;
      busy_q      <= 1'b0;
      left_q      <= '0;
      addr_out    <= '0;
      next_q      <= '0;
    end else begin
      addr_push   <= 1'b0;
      last_pushed <= 1'b0;
      if (start) begin
        addr_push <= 1'b1;
        addr_out  <= start_addr;
        next_q    <= start_addr + ADDR_W'(1);
        if (start_burst) begin
          if (start_len == '0) begin
            last_pushed <= 1'b1;
          end else begin
            busy_q <= 1'b1;
            left_q <= start_len;
          end
        end
      end else if (busy_q && !af_full) begin
        addr_push <= 1'b1;
        addr_out  <= next_q;
        next_q    <= next_q + ADDR_W'(1);
        left_q    <= left_q - LEN_W'(1);
        if (left_q == LEN_W'(1)) begin
          busy_q      <= 1'b0;
          last_pushed <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rdseq_ctrl.sv
module rdseq_ctrl
  import rdseq_pkg::*;
#(
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             rd_req,
  input  logic             burst,
  input  logic [LEN_W-1:0] burst_len,
  input  logic             af_full,
  input  logic             rd_valid,
  input  logic             bus_clk_lvl,
  input  logic             drain_last,
  input  logic             issue_last,
  output logic             start,
  output logic             cap_single,
  output logic             cap_burst,
  output logic             ack_next
);
  localparam int WL = LEN_W + 2;

  rdseq_state_e   st_q, st_d;
  logic           issuing_q;
  logic           mode_burst_q;
  logic [WL-1:0]  words_left_q;

  always_comb begin
    st_d       = st_q;
    start      = 1'b0;
    cap_single = 1'b0;
    cap_burst  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!issuing_q && sel && rd_req && !af_full) begin
          start = 1'b1;
          if (!burst) st_d = ST_WAIT;
        end else if (issuing_q && issue_last) begin
          st_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (rd_valid) begin
          if (mode_burst_q) begin
            cap_burst = 1'b1;
            st_d      = ST_QW1;
          end else begin
            cap_single = 1'b1;
            st_d       = bus_clk_lvl ? ST_ALIGN : ST_ACK1;
          end
        end
      end
      ST_ALIGN: st_d = ST_ACK1;
      ST_ACK1:  st_d = ST_ACK2;
      ST_ACK2:  st_d = ST_IDLE;
      ST_QW1: begin
        if (rd_valid) begin
          cap_burst = 1'b1;
          st_d      = ST_QW2;
        end
      end
      ST_QW2: begin
        if (words_left_q == '0) begin
          st_d = ST_DRAIN;
        end else if (rd_valid) begin
          cap_burst = 1'b1;
          st_d      = ST_QW1;
        end
      end
      ST_DRAIN: if (drain_last) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
    ack_next = (st_d == ST_ACK1) || (st_d == ST_ACK2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      issuing_q    <= 1'b0;
      mode_burst_q <= 1'b0;
      words_left_q <= '0;
    end else begin
      st_q <= st_d;
      if (start) begin
        mode_burst_q <= burst;
        issuing_q    <= burst;
        words_left_q <= (WL'(burst_len) + WL'(1)) << 1;
      end else begin
        if (issue_last) issuing_q <= 1'b0;
        if (cap_burst) words_left_q <= words_left_q - WL'(1);
      end
    end
  end
endmodule

// File: rtl/rdseq_dpath.sv
module rdseq_dpath #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              cap_single,
  input  logic              cap_burst,
  input  logic              ack_next,
  output logic              ack,
  output logic [DATA_W-1:0] bus_data,
  output logic              fifo_we,
  output logic [DATA_W-1:0] fifo_wdata
);
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack        <= 1'b0;
      bus_data   <= '0;
      fifo_we    <= 1'b0;
      fifo_wdata <= '0;
      hold_q     <= '0;
    end else begin
      fifo_we <= cap_burst;
      if (cap_burst)  fifo_wdata <= rd_word;
      if (cap_single) hold_q     <= rd_word;
      ack <= ack_next;
      if (ack_next) bus_data <= cap_single ? rd_word : hold_q;
      else          bus_data <= '0;
    end
  end
endmodule

// File: rtl/rdseq_top.sv
module rdseq_top #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              rd_req,
  input  logic              burst,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              af_full,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              bus_clk_lvl,
  input  logic              drain_last,
  output logic              ack,
  output logic [DATA_W-1:0] bus_data,
  output logic              fifo_we,
  output logic [DATA_W-1:0] fifo_wdata,
  output logic              addr_push,
  output logic [ADDR_W-1:0] addr_out
);
  logic start, cap_single, cap_burst, ack_next, issue_last;

  rdseq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .sel(sel), .rd_req(rd_req), .burst(burst),
    .burst_len(burst_len), .af_full(af_full), .rd_valid(rd_valid),
    .bus_clk_lvl(bus_clk_lvl), .drain_last(drain_last), .issue_last(issue_last),
    .start(start), .cap_single(cap_single), .cap_burst(cap_burst),
    .ack_next(ack_next)
  );

  rdseq_issue #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_issue (
    .clk(clk), .rst(rst), .start(start), .start_burst(burst),
    .start_addr(req_addr), .start_len(burst_len), .af_full(af_full),
    .addr_push(addr_push), .addr_out(addr_out), .last_pushed(issue_last)
  );

  rdseq_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst(rst), .rd_word(rd_word), .cap_single(cap_single),
    .cap_burst(cap_burst), .ack_next(ack_next), .ack(ack),
    .bus_data(bus_data), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata)
  );
endmodule

// File: rtl/rdseq_chk.sv
module rdseq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              af_full,
  input logic              rd_valid,
  input logic              ack,
  input logic [DATA_W-1:0] bus_data,
  input logic              fifo_we,
  input logic              addr_push
);
  p_push_af_r6: assert property (@(posedge clk) disable iff (rst)
    addr_push |-> !$past(af_full));
  p_ack_pair_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |=> ack);
  p_ack_max_two_r3: assert property (@(posedge clk) disable iff (rst)
    (ack && $past(ack)) |=> !ack);
  p_ack_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (ack && $past(ack)) |-> $stable(bus_data));
  p_data_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !ack |-> (bus_data == '0));
  p_we_valid_r8: assert property (@(posedge clk) disable iff (rst)
    fifo_we |-> $past(rd_valid));
  p_we_no_ack_r8: assert property (@(posedge clk) disable iff (rst)
    !(fifo_we && ack));
endmodule

bind rdseq_top rdseq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .af_full(af_full), .rd_valid(rd_valid), .ack(ack),
  .bus_data(bus_data), .fifo_we(fifo_we), .addr_push(addr_push)
);

// File: tb/sim_rdseq_top.sv
module sim_rdseq_top;
  localparam int DW = 16, AW = 12, LW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 0, rd_req = 0, burst = 0, af_full = 0, rd_valid = 0;
  logic bus_clk_lvl = 0, drain_last = 0;
  logic [LW-1:0] burst_len = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] rd_word = '0;
  logic ack, fifo_we, addr_push;
  logic [DW-1:0] bus_data, fifo_wdata;
  logic [AW-1:0] addr_out;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rdseq_top #(.DATA_W(DW), .ADDR_W(AW), .LEN_W(LW)) u0 (
    .clk(clk), .rst(rst), .sel(sel), .rd_req(rd_req), .burst(burst),
    .burst_len(burst_len), .req_addr(req_addr), .af_full(af_full),
    .rd_valid(rd_valid), .rd_word(rd_word), .bus_clk_lvl(bus_clk_lvl),
    .drain_last(drain_last), .ack(ack), .bus_data(bus_data),
    .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .addr_push(addr_push),
    .addr_out(addr_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic no_accept(input logic s, input logic r, input logic af);
    sel = s; rd_req = r; af_full = af; burst = 0; req_addr = 12'h0AB;
    for (int i = 0; i < 3; i++) begin
      step;
      chk(addr_push == 0, "R2 blocked request pushed", addr_push, 0);
    end
    sel = 0; rd_req = 0; af_full = 0;
  endtask

  task automatic single_rd(input logic [AW-1:0] a, input logic [DW-1:0] w,
                           input logic lvl, input int gap);
    sel = 1; rd_req = 1; burst = 0; req_addr = a; af_full = 0; rd_valid = 0;
    step;
    chk(addr_push == 1, "R2 push", addr_push, 1);
    chk(addr_out == a, "R2 addr", addr_out, a);
    req_addr = a + 12'h100;
    for (int i = 0; i < gap; i++) begin
      step;
      chk(addr_push == 0, "R9 request during single read", addr_push, 0);
      chk(ack == 0, "R5 ack before valid", ack, 0);
    end
    sel = 0; rd_req = 0;
    rd_valid = 1; rd_word = w; bus_clk_lvl = lvl;
    step;
    rd_valid = 0; rd_word = ~w; bus_clk_lvl = ~lvl;
    if (lvl) begin
      chk(ack == 0, "R4 align cycle", ack, 0);
      step;
    end
    chk(ack == 1, "R4 ack start", ack, 1);
    chk(bus_data == w, "R3 data first", bus_data, w);
    step;
    chk(ack == 1, "R3 ack second", ack, 1);
    chk(bus_data == w, "R3 data second", bus_data, w);
    step;
    chk(ack == 0, "R3 ack ends", ack, 0);
    chk(bus_data == 0, "R3 data cleared", bus_data, 0);
    bus_clk_lvl = 0;
  endtask

  task automatic burst_rd(input logic [AW-1:0] a, input int lenf,
                          input logic [7:0] afm, input logic [7:0] vm);
    int p, npush, nwr, cyc, lastp, first;
    logic prev_af;
    logic [DW-1:0] base;
    p = lenf + 1; base = DW'(16'h5000 + (lenf << 8) + a[3:0] * 16);
    sel = 1; rd_req = 1; burst = 1; burst_len = LW'(lenf); req_addr = a;
    af_full = 0; rd_valid = 0;
    step;
    sel = 0; rd_req = 0; burst = 0;
    chk(addr_push == 1 && addr_out == a, "R6 first push", addr_out, a);
    npush = 1; nwr = 0; cyc = 0; first = -1;
    lastp = (p == 1) ? 0 : -1;
    while (nwr < 2 * p && cyc < 300) begin
      cyc++;
      af_full = afm[cyc % 8]; rd_valid = vm[cyc % 8];
      rd_word = base + DW'(nwr);
      prev_af = af_full;
      step;
      if (addr_push) begin
        chk(prev_af == 0, "R6 push after almost-full", prev_af, 0);
        chk(addr_out == a + AW'(npush), "R6 address order", addr_out, a + AW'(npush));
        npush++;
        if (npush == p) lastp = cyc;
      end
      if (fifo_we) begin
        if (nwr == 0) begin
          first = cyc;
          chk(lastp >= 0 && cyc - lastp >= 2, "R7 write before wait", cyc, lastp + 2);
          if (vm == 8'hFF) chk(cyc == lastp + 2, "R7 wait entry timing", cyc, lastp + 2);
        end
        chk(fifo_wdata == base + DW'(nwr), "R8 write data", fifo_wdata, base + DW'(nwr));
        nwr++;
      end
    end
    chk(npush == p, "R6 push count", npush, p);
    chk(nwr == 2 * p, "R8 write count", nwr, 2 * p);
    af_full = 0; rd_valid = 1; sel = 1; rd_req = 1; req_addr = 12'h3C0;
    for (int i = 0; i < 4; i++) begin
      step;
      chk(fifo_we == 0, "R8 extra valid written", fifo_we, 0);
      chk(addr_push == 0, "R9 request before drain", addr_push, 0);
    end
    sel = 0; rd_req = 0; rd_valid = 0; drain_last = 1;
    step;
    drain_last = 0;
    chk(ack == 0 && fifo_we == 0, "R9 drain return", ack, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] afs [4];
    logic [7:0] vms [4];
    afs = '{8'h00, 8'h55, 8'h36, 8'h0E};
    vms = '{8'hFF, 8'hAA, 8'h1E, 8'h77};
    @(negedge clk);
    step; step;
    chk(ack == 0 && bus_data == 0, "R1 reset ack/data", ack, 0);
    chk(fifo_we == 0 && addr_push == 0, "R1 reset strobes", fifo_we, 0);
    rst = 0;
    step;
    chk(ack == 0 && fifo_we == 0 && addr_push == 0, "R1 after reset", addr_push, 0);

    no_accept(1, 1, 1);
    no_accept(1, 0, 0);
    no_accept(0, 1, 0);

    for (int lvl = 0; lvl < 2; lvl++)
      for (int g = 0; g < 4; g++)
        single_rd(AW'(12'h100 + lvl * 16 + g), DW'(16'hA000 + lvl * 256 + g * 17),
                  lvl[0], g);

    for (int l = 0; l < 4; l++)
      for (int m = 0; m < 4; m++)
        burst_rd(AW'(12'h200 + l * 64 + m * 8), l, afs[m], vms[m]);

    single_rd(12'h7FF, 16'h1234, 1'b0, 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule